// File: doc/BRIEF.md
# External Pin Interrupt Sense Unit

This block watches a set of external interrupt pins (eight by default) and turns activity on them into latched interrupt events. Every pin first passes through a two-flop synchroniser. A per-pin sense mode, programmed over a simple 32-bit register bus, selects which condition is detected: the pin being low, a falling edge, a rising edge, or either edge. Detected conditions land in a status register. A mask register gates each status bit before it reaches the upstream interrupt controller as an active-high level request.

In an edge mode a status bit is sticky. Software clears it by writing zero to that bit. In the level-low mode the status bit tracks the synchronised pin, and software writes to it change nothing. When a new edge and a clear arrive in the same cycle, the edge is kept, so no event is lost. The bus has no handshake: a write completes in one cycle, and read data follows the address combinationally. No data stream passes through the block, so all of its ports are plain control and status signals.

Top module: `pin_irq_sense`

## Requirements
- R1: After reset, the sense, status and mask registers read 0 and every request output is 0. The synchroniser flops and the previous-value flops reset to 1, which is the idle-high state of the pins.
- R2: The status register sits at byte address 0x10, the sense-select register at 0x14 and the mask register at 0x10010. The sense field of pin n is bits [2n+1:2n], and status and mask use bit n for pin n. Read data above the used width is 0. Any other address reads 0 and ignores writes.
- R3: Sense code 1 selects falling edge. A high-to-low change on the pin sets its status bit three clock edges after the change is first sampled. A low-to-high change does not set it.
- R4: Sense code 2 selects rising edge. A low-to-high change sets the status bit with the same three-edge latency. A high-to-low change does not set it.
- R5: Sense code 3 selects both edges. Either change sets the status bit.
- R6: Sense code 0 selects level low. On every cycle the status bit becomes the inverse of the synchronised pin, and a status write of 0 leaves it unchanged.
- R7: In any edge mode, writing 0 to a set status bit clears it on the next clock edge. Writing 1 has no effect. Bits of other pins are left alone.
- R8: If an edge event and a clearing write to the same bit occur in the same cycle, the status bit stays set.
- R9: The request output for pin n is 1 exactly when status bit n is 1 and mask bit n is 0.
- R10: In an edge mode, a set status bit holds its value when there is no clearing write, whatever the pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | External interrupt pins, asynchronous |
| bus_addr | input | 20 | Register byte address |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_req_o | output | 8 | Active-high level request per pin |

## Verification
Three properties are checked on every cycle. No request is raised while its mask bit is set. In an edge mode, a status bit rises only when the synchronised pin has changed, and once set it is kept unless a status write occurs. In level-low mode, status equals the inverted synchronised pin of the previous cycle. The bench scenarios are what show the rest: the exact three-edge latency, which edge each sense code accepts, the register map and its read-back, write-one being harmless, and the event winning over a clear in the same cycle.

// File: rtl/pis_pkg.sv
package pis_pkg;

  typedef enum logic [1:0] {
    SENSE_LVL_LOW = 2'd0,
    SENSE_FALL    = 2'd1,
    SENSE_RISE    = 2'd2,
    SENSE_BOTH    = 2'd3
  } sense_e;

  localparam logic [19:0] DEF_STAT_OFS  = 20'h00010;
  localparam logic [19:0] DEF_SENSE_OFS = 20'h00014;
  localparam logic [19:0] DEF_MASK_OFS  = 20'h10010;

endpackage

// File: rtl/pis_sync.sv
module pis_sync #(
  parameter int unsigned W = 8,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/pis_lane.sv
module pis_lane
  import pis_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_i,
  input  sense_e sense_i,
  input  logic   clr_i,
  output logic   status_o
);

  logic prev_q;
  logic status_q;
  logic evt;
  logic status_d;

  always_comb begin
    unique case (sense_i)
      SENSE_FALL: evt = prev_q & ~sync_i;
      SENSE_RISE: evt = ~prev_q & sync_i;
      SENSE_BOTH: evt = prev_q ^ sync_i;
      default:    evt = 1'b0;
    endcase
  end

  always_comb begin
    if (sense_i == SENSE_LVL_LOW) status_d = ~sync_i;
    else                          status_d = evt | (status_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b1;
      status_q <= 1'b0;
    end else begin
      prev_q   <= sync_i;
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

endmodule

// File: rtl/pis_regs.sv
module pis_regs #(
  parameter int unsigned N_PINS    = 8,
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS  = ADDR_W'(20'h00010),
  parameter logic [ADDR_W-1:0] SENSE_OFS = ADDR_W'(20'h00014),
  parameter logic [ADDR_W-1:0] MASK_OFS  = ADDR_W'(20'h10010)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [N_PINS-1:0]   status_i,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [2*N_PINS-1:0] sense_o,
  output logic [N_PINS-1:0]   mask_o,
  output logic [N_PINS-1:0]   clr_o
);

  localparam int unsigned SW = 2 * N_PINS;

  logic [SW-1:0]     sense_q;
  logic [N_PINS-1:0] mask_q;
  logic              hit_stat, hit_sense, hit_mask;
  logic              unused_wdata;

  assign hit_stat  = (bus_addr == STAT_OFS);
  assign hit_sense = (bus_addr == SENSE_OFS);
  assign hit_mask  = (bus_addr == MASK_OFS);
  assign unused_wdata = ^bus_wdata[DATA_W-1:SW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      mask_q  <= '0;
    end else if (bus_we) begin
      if (hit_sense) sense_q <= bus_wdata[SW-1:0];
      if (hit_mask)  mask_q  <= bus_wdata[N_PINS-1:0];
    end
  end

  assign clr_o = (bus_we && hit_stat) ? ~bus_wdata[N_PINS-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    if (hit_stat)       bus_rdata[N_PINS-1:0] = status_i;
    else if (hit_sense) bus_rdata[SW-1:0]     = sense_q;
    else if (hit_mask)  bus_rdata[N_PINS-1:0] = mask_q;
  end

  assign sense_o = sense_q;
  assign mask_o  = mask_q;

endmodule

// File: rtl/pin_irq_sense.sv
module pin_irq_sense
  import pis_pkg::*;
#(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_PINS-1:0] irq_req_o
);

  localparam int unsigned SW = 2 * N_PINS;

  logic [N_PINS-1:0] pin_sync;
  logic [N_PINS-1:0] status_vec;
  logic [N_PINS-1:0] mask_vec;
  logic [N_PINS-1:0] clr_vec;
  logic [SW-1:0]     sense_vec;

  pis_sync #(.W(N_PINS), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  pis_regs #(
    .N_PINS    (N_PINS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .STAT_OFS  (ADDR_W'(DEF_STAT_OFS)),
    .SENSE_OFS (ADDR_W'(DEF_SENSE_OFS)),
    .MASK_OFS  (ADDR_W'(DEF_MASK_OFS))
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .status_i  (status_vec),
    .bus_rdata (bus_rdata),
    .sense_o   (sense_vec),
    .mask_o    (mask_vec),
    .clr_o     (clr_vec)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_lane
    pis_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (pin_sync[i]),
      .sense_i  (sense_e'(sense_vec[2*i +: 2])),
      .clr_i    (clr_vec[i]),
      .status_o (status_vec[i])
    );
  end

  assign irq_req_o = status_vec & ~mask_vec;

endmodule

// File: rtl/pis_checker.sv
module pis_checker #(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned ADDR_W = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [N_PINS-1:0]   pin_sync,
  input logic [N_PINS-1:0]   status_vec,
  input logic [N_PINS-1:0]   mask_vec,
  input logic [2*N_PINS-1:0] sense_vec,
  input logic [N_PINS-1:0]   irq_req_o
);

  logic stat_wr;
  assign stat_wr = bus_we && (bus_addr == ADDR_W'(pis_pkg::DEF_STAT_OFS));

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_req_o & mask_vec) == 0) else $error("masked request seen"); // R9

  for (genvar i = 0; i < N_PINS; i++) begin : g_chk
    AST_EDGE_ONLY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_vec[2*i +: 2] != 2'd0 && !status_vec[i] && $stable(pin_sync[i]))
      |=> !status_vec[i]) else $error("status rose without an edge"); // R3

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_vec[2*i +: 2] != 2'd0 && status_vec[i] && !stat_wr)
      |=> status_vec[i]) else $error("edge status lost"); // R10

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_vec[2*i +: 2] == 2'd0) |=> (status_vec[i] == !$past(pin_sync[i])))
      else $error("level status mismatch"); // R6
  end

endmodule

bind pin_irq_sense pis_checker #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_pis_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .pin_sync   (pin_sync),
  .status_vec (status_vec),
  .mask_vec   (mask_vec),
  .sense_vec  (sense_vec),
  .irq_req_o  (irq_req_o)
);

// File: tb/pin_irq_sense_bench.sv
module pin_irq_sense_bench;

  localparam logic [19:0] A_STAT  = 20'h00010;
  localparam logic [19:0] A_SENSE = 20'h00014;
  localparam logic [19:0] A_MASK  = 20'h10010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_i = 8'hFF;
  logic [19:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_irq_sense u_pin_irq_sense (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req_o(irq_req_o)
  );

  // {sense code, pin start, pin end, expected status bit 0}
  typedef struct packed {
    logic [1:0] code;
    logic       from;
    logic       to;
    logic       exp;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{2'd1, 1'b1, 1'b0, 1'b1},   // R3 falling sets
    '{2'd1, 1'b0, 1'b1, 1'b0},   // R3 rising ignored
    '{2'd2, 1'b0, 1'b1, 1'b1},   // R4 rising sets
    '{2'd2, 1'b1, 1'b0, 1'b0},   // R4 falling ignored
    '{2'd3, 1'b1, 1'b0, 1'b1},   // R5
    '{2'd3, 1'b0, 1'b1, 1'b1},   // R5
    '{2'd0, 1'b1, 1'b0, 1'b1},   // R6 low level
    '{2'd0, 1'b0, 1'b1, 1'b0}    // R6 high level
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, r);  check(r == 0, "R1 status", r, 0);
    rd(A_SENSE, r); check(r == 0, "R1 sense", r, 0);
    rd(A_MASK, r);  check(r == 0, "R1 mask", r, 0);
    check(irq_req_o == 0, "R1 irq", {24'h0, irq_req_o}, 0);

    // R2 register map
    wr(A_SENSE, 32'hFFFF_A5C3);
    rd(A_SENSE, r); check(r == 32'h0000_A5C3, "R2 sense readback", r, 32'h0000_A5C3);
    wr(A_MASK, 32'hFFFF_FF5A);
    rd(A_MASK, r);  check(r == 32'h5A, "R2 mask readback", r, 32'h5A);
    wr(20'h00018, 32'hFFFF_FFFF);
    rd(20'h00018, r); check(r == 0, "R2 unmapped", r, 0);
    rd(A_SENSE, r); check(r == 32'h0000_A5C3, "R2 unmapped write ignored", r, 32'h0000_A5C3);
    wr(A_MASK, 32'h0);

    // Table walk on pin 0
    for (int k = 0; k < 8; k++) begin
      pin_i[0] = VECS[k].from;
      repeat (4) @(negedge clk);
      wr(A_SENSE, {30'h0, VECS[k].code});
      wr(A_STAT, 32'h0);
      pin_i[0] = VECS[k].to;
      repeat (3) @(negedge clk);
      rd(A_STAT, r);
      check(r[0] == VECS[k].exp, $sformatf("R3/R4/R5/R6 vec%0d", k), {31'h0, r[0]},
            {31'h0, VECS[k].exp});
    end

    // R7 clearing in rising mode
    pin_i = 8'h00;
    wr(A_SENSE, 32'hAAAA);
    repeat (4) @(negedge clk);
    wr(A_STAT, 32'h0);
    pin_i = 8'hFF;
    repeat (3) @(negedge clk);
    rd(A_STAT, r); check(r == 32'hFF, "R4 all pins rising", r, 32'hFF);
    wr(A_STAT, 32'hF0);
    rd(A_STAT, r); check(r == 32'hF0, "R7 write-zero clears, write-one kept", r, 32'hF0);

    // R9 masking
    check(irq_req_o == 8'hF0, "R9 irq unmasked", {24'h0, irq_req_o}, 32'hF0);
    wr(A_MASK, 32'h30);
    check(irq_req_o == 8'hC0, "R9 irq masked", {24'h0, irq_req_o}, 32'hC0);
    wr(A_MASK, 32'h0);

    // R10 sticky after pins fall in rising mode
    pin_i = 8'h00;
    repeat (5) @(negedge clk);
    rd(A_STAT, r); check(r == 32'hF0, "R10 sticky", r, 32'hF0);

    // R6 clear ignored in level-low mode (pin 0 low)
    wr(A_SENSE, 32'hAAA8);
    repeat (3) @(negedge clk);
    wr(A_STAT, 32'h0);
    rd(A_STAT, r); check(r == 32'h01, "R6 level clear ignored", r, 32'h01);

    // R8 event and clear in the same cycle on pin 1
    pin_i[1] = 1'b1;
    repeat (2) @(negedge clk);
    wr(A_STAT, 32'h0);
    rd(A_STAT, r); check(r[1] == 1'b1, "R8 event wins over clear", {31'h0, r[1]}, 1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, r); check(r[1] == 1'b0, "R7 later clear works", {31'h0, r[1]}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule